// File: doc/BRIEF.md
# Accumulator Stored-Program Core

This block is a minimal processor that keeps its program and its data in one shared memory. It holds a program counter, an instruction register, an accumulator, and a pair of registers that sit between the core and the memory: one holds the address presented to memory and one holds the word moving to or from it. Every instruction runs as a fetch phase followed by an execute phase. The fetch phase reads the word at the program counter. The execute phase carries out the operation that word encodes.

An instruction word is 16 bits. The upper 4 bits select the operation and the lower 12 bits give a direct word address. The core can load, store and add a memory word, jump unconditionally, and halt. The memory port is synchronous and has a single port. Read data appears one clock after its address. After halting, the core raises a status output and stops all memory traffic. The accumulator drives an output port so it can be observed.

Top module: `accCore`

## Requirements
- R1: An instruction word has its opcode in bits 15..12 and a direct operand address in bits 11..0.
- R2: Opcode 0x1 copies the memory word at the operand address into the accumulator.
- R3: Opcode 0x2 writes the accumulator to the operand address. Store is the only operation that asserts the write enable, and it asserts it for exactly one cycle.
- R4: Opcode 0x5 adds the memory word at the operand address to the accumulator, modulo 2^16, with no carry kept.
- R5: Opcode 0x8 sets the program counter to the operand address, so the next fetch is taken from there.
- R6: Opcode 0xF halts the core. Once halted, the halt output stays high, the write enable stays low, and the address and the accumulator hold their values until reset.
- R7: Every other opcode changes neither the accumulator nor memory, and execution continues at the next sequential address.
- R8: Synchronous reset clears the program counter, the accumulator and the halt state. The first fetch after reset reads address 0.
- R9: The program counter advances by one on each fetch. From the start of its fetch, an instruction takes 4 cycles for jump, halt and no-op, 5 cycles for store, and 6 cycles for load and add.
- R10: The memory address always comes from the address register, and store data always comes from the data-buffer register, which holds the accumulator value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | 12 | Memory word address |
| memWdata | output | 16 | Memory write data |
| memWe | output | 1 | Memory write enable |
| memRdata | input | 16 | Memory read data, valid one cycle after the address |
| halted | output | 1 | High once a halt instruction has executed |
| accOut | output | 16 | Current accumulator value |

## Verification
A load-add-store-halt program is run for a set of operand pairs. The pairs range from small values to ones whose sum wraps past 16 bits. This separates correct modulo addition from a wrong or truncated sum, and the stored result confirms the write path. A second program jumps over a load that must be skipped and includes a no-op before a store. This separates a jump that is taken from a program counter that simply increments. Every unused opcode is swept in the slot after a load, and the accumulator and a memory sentinel are checked afterwards. The number of cycles from reset to halt is compared with the per-opcode counts in each program, so a missing or extra state shows up as a timing error.

// File: rtl/accCorePkg.sv
package accCorePkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_LOAD  = 4'h1;
  localparam logic [OPC_W-1:0] OP_STORE = 4'h2;
  localparam logic [OPC_W-1:0] OP_ADD   = 4'h5;
  localparam logic [OPC_W-1:0] OP_JUMP  = 4'h8;
  localparam logic [OPC_W-1:0] OP_HALT  = 4'hF;

  typedef enum logic [2:0] {
    ST_FETCH_ADDR,
    ST_FETCH_DATA,
    ST_DECODE,
    ST_EXEC_ADDR,
    ST_EXEC_DATA,
    ST_EXEC_WB,
    ST_HALT
  } phaseT;

  typedef struct packed {
    logic marFromPc;
    logic marFromIr;
    logic pcInc;
    logic pcFromIr;
    logic irLoad;
    logic mbrFromMem;
    logic mbrFromAcc;
    logic accLoad;
    logic accAdd;
    logic memWrite;
  } strobeT;

endpackage

// File: rtl/accCoreCtrl.sv
module accCoreCtrl
  import accCorePkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] irOp,
  output strobeT           str,
  output logic             halted
);

  phaseT phase;
  phaseT phaseNext;

  always_ff @(posedge clk) begin
    if (rst) phase <= ST_FETCH_ADDR;
    else     phase <= phaseNext;
  end

  assign halted = (phase == ST_HALT);

  always_comb begin
    str       = '0;
    phaseNext = phase;
    unique case (phase)
      ST_FETCH_ADDR: begin
        str.marFromPc = 1'b1;
        phaseNext     = ST_FETCH_DATA;
      end
      ST_FETCH_DATA: begin
        str.pcInc = 1'b1;
        phaseNext = ST_DECODE;
      end
      ST_DECODE: begin
        str.irLoad     = 1'b1;
        str.mbrFromMem = 1'b1;
        phaseNext      = ST_EXEC_ADDR;
      end
      ST_EXEC_ADDR: begin
        if (irOp == OP_LOAD || irOp == OP_ADD || irOp == OP_STORE) begin
          str.marFromIr  = 1'b1;
          str.mbrFromAcc = (irOp == OP_STORE);
          phaseNext      = ST_EXEC_DATA;
        end else if (irOp == OP_JUMP) begin
          str.pcFromIr = 1'b1;
          phaseNext    = ST_FETCH_ADDR;
        end else if (irOp == OP_HALT) begin
          phaseNext = ST_HALT;
        end else begin
          phaseNext = ST_FETCH_ADDR;
        end
      end
      ST_EXEC_DATA: begin
        if (irOp == OP_STORE) begin
          str.memWrite = 1'b1;
          phaseNext    = ST_FETCH_ADDR;
        end else begin
          phaseNext = ST_EXEC_WB;
        end
      end
      ST_EXEC_WB: begin
        str.mbrFromMem = 1'b1;
        str.accLoad    = (irOp == OP_LOAD);
        str.accAdd     = (irOp == OP_ADD);
        phaseNext      = ST_FETCH_ADDR;
      end
      ST_HALT: phaseNext = ST_HALT;
      default: phaseNext = ST_FETCH_ADDR;
    endcase
  end

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R6

  AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    str.memWrite |=> !str.memWrite); // R3

  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    halted |-> !str.memWrite); // R6

endmodule

// File: rtl/accCoreDp.sv
module accCoreDp
  import accCorePkg::*;
#(
  parameter int DATA_W = 16,
  localparam int ADDR_W = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  strobeT            str,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic [OPC_W-1:0]  irOp,
  output logic [DATA_W-1:0] accOut
);

  logic [ADDR_W-1:0] pcQ;
  logic [ADDR_W-1:0] marQ;
  logic [DATA_W-1:0] irQ;
  logic [DATA_W-1:0] mbrQ;
  logic [DATA_W-1:0] accQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ  <= '0;
      marQ <= '0;
      irQ  <= '0;
      mbrQ <= '0;
      accQ <= '0;
    end else begin
      if (str.pcFromIr)        pcQ <= irQ[ADDR_W-1:0];
      else if (str.pcInc)      pcQ <= pcQ + 1'b1;
      if (str.marFromPc)       marQ <= pcQ;
      else if (str.marFromIr)  marQ <= irQ[ADDR_W-1:0];
      if (str.irLoad)          irQ <= memRdata;
      if (str.mbrFromAcc)      mbrQ <= accQ;
      else if (str.mbrFromMem) mbrQ <= memRdata;
      if (str.accLoad)         accQ <= memRdata;
      else if (str.accAdd)     accQ <= accQ + memRdata;
    end
  end

  assign memAddr  = marQ;
  assign memWdata = mbrQ;
  assign memWe    = str.memWrite;
  assign irOp     = irQ[DATA_W-1:ADDR_W];
  assign accOut   = accQ;

  AST_STORE_DATA: assert property (@(posedge clk) disable iff (rst)
    str.memWrite |-> (memWdata == accQ)); // R10

  AST_STORE_ADDR: assert property (@(posedge clk) disable iff (rst)
    str.memWrite |-> (memAddr == irQ[ADDR_W-1:0])); // R1

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(str.accLoad || str.accAdd) |=> $stable(accQ)); // R7

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (str.pcInc && !str.pcFromIr) |=> (pcQ == $past(pcQ) + 1'b1)); // R9

endmodule

// File: rtl/accCore.sv
module accCore
  import accCorePkg::*;
#(
  parameter int DATA_W = 16,
  localparam int ADDR_W = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  input  logic [DATA_W-1:0] memRdata,
  output logic              halted,
  output logic [DATA_W-1:0] accOut
);

  strobeT           str;
  logic [OPC_W-1:0] irOp;

  accCoreCtrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .irOp   (irOp),
    .str    (str),
    .halted (halted)
  );

  accCoreDp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .str      (str),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memWe    (memWe),
    .irOp     (irOp),
    .accOut   (accOut)
  );

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(memAddr) && !memWe && $stable(accOut))); // R6

endmodule

// File: tb/accCore_tb.sv
module accCore_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] memAddr;
  logic [15:0] memWdata;
  logic        memWe;
  logic [15:0] memRdata;
  logic        halted;
  logic [15:0] accOut;

  logic [15:0] mem [256];
  int          writeCount;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  accCore u_dut (
    .clk      (clk),
    .rst      (rst),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memWe    (memWe),
    .memRdata (memRdata),
    .halted   (halted),
    .accOut   (accOut)
  );

  always @(posedge clk) begin
    if (memWe) begin
      mem[memAddr[7:0]] <= memWdata;
      writeCount <= writeCount + 1;
    end
    memRdata <= mem[memAddr[7:0]];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = 16'hDEAD;
    writeCount = 0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic runToHalt(output int cycles);
    cycles = 0;
    while (!halted && cycles < 300) begin
      @(posedge clk);
      #1;
      cycles++;
    end
  endtask

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
    return {op, a};
  endfunction

  initial begin
    int cyc;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] expSum;
    logic [11:0] heldAddr;
    logic [15:0] heldAcc;

    clearMem();
    mem[0] = ins(4'hF, 12'h000);
    doReset();
    #1;
    check(accOut == 16'h0, "R8 acc after reset", accOut, 0);
    check(!halted, "R8 halted after reset", halted, 0);
    check(memAddr == 12'h0, "R8 address after reset", memAddr, 0);
    @(posedge clk); #1;
    check(memAddr == 12'h0, "R8 first fetch address", memAddr, 0);
    check(!memWe, "R3 no write during fetch", memWe, 0);

    // R2 R4 R3 R1 R9: load/add/store/halt sweep over operand pairs
    for (int i = 0; i < 20; i++) begin
      a = 16'(i * 16'h1357 + 16'h0F0F);
      b = 16'(16'hFFFF - i * 16'h0ACE);
      if (i == 18) begin a = 16'hFFFF; b = 16'h0001; end
      if (i == 19) begin a = 16'h8000; b = 16'h8000; end
      expSum = 16'((32'(a) + 32'(b)) % 32'h10000);
      clearMem();
      mem[0] = ins(4'h1, 12'h020);
      mem[1] = ins(4'h5, 12'h021);
      mem[2] = ins(4'h2, 12'h030);
      mem[3] = ins(4'hF, 12'h000);
      mem[8'h20] = a;
      mem[8'h21] = b;
      doReset();
      runToHalt(cyc);
      check(accOut == expSum, "R4 sum modulo 2^16", accOut, expSum);
      check(mem[8'h30] == expSum, "R3 stored value", mem[8'h30], expSum);
      check(writeCount == 1, "R3 single write", writeCount, 1);
      check(cyc == 21, "R9 cycles load+add+store+halt", cyc, 21);
    end

    // R2 alone: load then halt
    clearMem();
    mem[0] = ins(4'h1, 12'h044);
    mem[1] = ins(4'hF, 12'h000);
    mem[8'h44] = 16'hA5C3;
    doReset();
    runToHalt(cyc);
    check(accOut == 16'hA5C3, "R2 load value", accOut, 16'hA5C3);
    check(cyc == 10, "R9 cycles load+halt", cyc, 10);

    // R5 R7 R10: jump over a load, no-op, then store
    clearMem();
    mem[0]     = ins(4'h8, 12'h010);
    mem[1]     = ins(4'h1, 12'h060);
    mem[8'h10] = ins(4'h1, 12'h061);
    mem[8'h11] = ins(4'h3, 12'h041);
    mem[8'h12] = ins(4'h2, 12'h040);
    mem[8'h13] = ins(4'hF, 12'h000);
    mem[8'h60] = 16'h1111;
    mem[8'h61] = 16'h7E57;
    mem[8'h41] = 16'hBEEF;
    doReset();
    runToHalt(cyc);
    check(accOut == 16'h7E57, "R5 jump skipped load", accOut, 16'h7E57);
    check(mem[8'h40] == 16'h7E57, "R10 store data from acc", mem[8'h40], 16'h7E57);
    check(mem[8'h41] == 16'hBEEF, "R7 no-op left memory", mem[8'h41], 16'hBEEF);
    check(cyc == 23, "R9 cycles jump+load+nop+store+halt", cyc, 23);

    // R6: halted core stays quiet
    heldAddr = memAddr;
    heldAcc  = accOut;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #1;
      check(halted && !memWe && memAddr == heldAddr && accOut == heldAcc,
            "R6 halt frozen", {halted, memWe}, 2);
    end
    check(writeCount == 1, "R6 no writes after halt", writeCount, 1);

    // R7: sweep every unused opcode
    for (int op = 0; op < 16; op++) begin
      if (op == 1 || op == 2 || op == 5 || op == 8 || op == 15) continue;
      clearMem();
      mem[0] = ins(4'h1, 12'h070);
      mem[1] = ins(4'(op), 12'h050);
      mem[2] = ins(4'hF, 12'h000);
      mem[8'h70] = 16'h3C3C + 16'(op);
      mem[8'h50] = 16'h5A5A;
      doReset();
      runToHalt(cyc);
      check(accOut == 16'h3C3C + 16'(op), "R7 unused opcode keeps acc", accOut, 16'h3C3C + 16'(op));
      check(mem[8'h50] == 16'h5A5A && writeCount == 0, "R7 unused opcode no write", mem[8'h50], 16'h5A5A);
      check(cyc == 14, "R9 cycles load+nop+halt", cyc, 14);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule